// File: doc/BRIEF.md
# BCD Calendar Counter with Prescaler

This block keeps wall-clock time from a 32768 Hz clock-enable tick. It runs entirely in the system clock domain: a binary prescaler counts ticks, a binary seconds counter counts prescaler wraps, and a chain of BCD fields holds minutes, hours, day of month and month. Three square waves come out of the chain: a 128 Hz trim reference, a 1 Hz wave and a one-minute wave. The minute field moves when the one-minute wave falls.

Two single-cycle commands act on the sub-minute state. The first clears the prescaler and the seconds counter and leaves the minutes alone. The second does the same clear, but it also rounds to the nearest minute: it carries into the minutes when the seconds count was 30 or more. Software can load any of the four time fields directly.

The length of each month comes from a fixed table. Leap years are not tracked. For a leap February, the day field is written to 29, and it then rolls over after 29.

Top module: `rtc_calendar_core`

## Requirements
- R11: After reset the fields read minutes 00, hours 00, days 01 and months 01. trim_out, sec_sq and min_sq are all low.
- R1: trim_out is a 1:1 square wave with a period of 2^(PRE_W-7) ticks, which is 128 Hz at the default PRE_W=15. After a prescaler clear it goes high on the 2^(PRE_W-8)-th tick.
- R2: sec_sq is a 1:1 square wave with a period of 2^PRE_W ticks. After a prescaler clear it is low for the first half of each second and high for the second half.
- R3: min_sq is high while the seconds count is 30 to 59 and low while it is 00 to 29. It therefore changes only on falling edges of sec_sq.
- R4: The minutes field advances by one, in BCD, in the cycle where min_sq falls from counting. This happens 60 seconds of ticks after a clear. Minutes wrap from 59 to 00 and hours from 23 to 00, and each wrap carries one into the next field.
- R5: The day field rolls to 01 and carries into the month once the day is at or above the month's limit. The limit is 28 for month 02, 30 for months 04, 06, 09 and 11, and 31 for every other month. Months wrap from 12 to 01.
- R6: With month 02, a day written to 29 advances to 01 on the next day carry, and the month moves to 03.
- R7: cmd_prescale_clr zeroes the prescaler and the seconds counter on the next clock. It never changes the minutes, whatever the seconds count was.
- R8: cmd_round_adj zeroes the prescaler and the seconds counter. It carries one into the minutes only when the seconds count was 30 or more. If both commands are asserted together, the adjust takes effect. Either command overrides a tick in the same cycle.
- R9: While wr_en is high, the field chosen by wr_sel takes the BCD value in the low bits of wr_data on the next clock. The wr_sel codes are 0 = minutes (wr_data[6:0]), 1 = hours ([5:0]), 2 = days ([5:0]) and 3 = months ([4:0]). An advance that falls on the written field in that cycle is dropped, together with any carry out of that field. The other fields still advance.
- R10: While tick_en is low and no command or write is present, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | 32768 Hz timebase enable, one clock wide per tick |
| cmd_prescale_clr | input | 1 | Clear prescaler and seconds, no minute carry |
| cmd_round_adj | input | 1 | Clear prescaler and seconds, carry if seconds >= 30 |
| wr_en | input | 1 | Direct field write strobe |
| wr_sel | input | 2 | Field select: 0 min, 1 hour, 2 day, 3 month |
| wr_data | input | 7 | BCD value for the selected field |
| trim_out | output | 1 | 128 Hz trim reference square wave |
| sec_sq | output | 1 | 1 Hz square wave |
| min_sq | output | 1 | One-minute square wave |
| minutes | output | 7 | BCD minutes 00-59 |
| hours | output | 6 | BCD hours 00-23 |
| days | output | 6 | BCD day of month |
| months | output | 5 | BCD month 01-12 |

## Verification
The calendar chain is tested with a table of loaded dates, each followed by one minute carry.

- A plain mid-hour date shows that the BCD increment works.
- Dates at 59 minutes and at 23:59 exercise the minute and hour carries.
- One date ends each class of month: 28-day, 30-day and 31-day, including day 30 in a 31-day month.
- A written 29 February and 31 December cover the remaining month cases.

Together these separate a wrong month table, an off-by-one limit and a missing carry.

Directed runs cover the remaining behaviour:

- the square-wave phases counted from a clear;
- a full natural minute;
- both commands, taken with early and with late seconds;
- a write landing in the same cycle as a carry, on the carrying field and on a downstream field.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int MIN_W  = 7;
  localparam int HOUR_W = 6;
  localparam int DAY_W  = 6;
  localparam int MON_W  = 5;

  typedef enum logic [1:0] {
    FLD_MIN  = 2'd0,
    FLD_HOUR = 2'd1,
    FLD_DAY  = 2'd2,
    FLD_MON  = 2'd3
  } field_sel_e;

  // BCD increment of a two-digit value
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // last day of the month, BCD, no leap-year logic
  function automatic logic [7:0] month_last_day(input logic [7:0] m);
    logic [7:0] r;
    case (m)
      8'h02:                      r = 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRE_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic cmd_clr,
  input  logic cmd_adj,
  output logic trim_out,
  output logic sec_sq,
  output logic min_sq,
  output logic min_carry
);
  localparam int               TRIM_BIT = PRE_W - 8;
  localparam logic [PRE_W-1:0] PRE_ONE  = PRE_W'(1);
  localparam logic [5:0]       SEC_LAST = 6'd59;
  localparam logic [5:0]       SEC_HALF = 6'd30;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [5:0]       sec_q, sec_d;
  logic             late;

  assign late = (sec_q >= SEC_HALF);

  always_comb begin
    pre_d     = pre_q;
    sec_d     = sec_q;
    min_carry = 1'b0;
    if (cmd_adj) begin
      pre_d     = '0;
      sec_d     = '0;
      min_carry = late;
    end else if (cmd_clr) begin
      pre_d = '0;
      sec_d = '0;
    end else if (tick_en) begin
      pre_d = pre_q + PRE_ONE;
      if (&pre_q) begin
        if (sec_q == SEC_LAST) begin
          sec_d     = '0;
          min_carry = 1'b1;
        end else begin
          sec_d = sec_q + 6'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sec_q <= '0;
    end else begin
      pre_q <= pre_d;
      sec_q <= sec_d;
    end
  end

  assign trim_out = pre_q[TRIM_BIT];
  assign sec_sq   = pre_q[PRE_W-1];
  assign min_sq   = late;
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter int         W       = 7,
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         at_limit,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] value
);
  import rtc_cal_pkg::*;

  localparam logic [W-1:0] WRAP_VAL = W'(RST_VAL);

  logic [W-1:0] value_d;

  always_comb begin
    value_d = value;
    if (wr_en)         value_d = wr_val;
    else if (adv) begin
      if (at_limit)    value_d = WRAP_VAL;
      else             value_d = W'(bcd_inc(8'(value)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= WRAP_VAL;
    else        value <= value_d;
  end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int PRE_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              cmd_prescale_clr,
  input  logic              cmd_round_adj,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [MIN_W-1:0]  wr_data,
  output logic              trim_out,
  output logic              sec_sq,
  output logic              min_sq,
  output logic [MIN_W-1:0]  minutes,
  output logic [HOUR_W-1:0] hours,
  output logic [DAY_W-1:0]  days,
  output logic [MON_W-1:0]  months
);
  logic rst_core_n;
  logic min_adv, hour_adv, day_adv, mon_adv;
  logic min_top, hour_top, day_top, mon_top;
  logic wr_min, wr_hour, wr_day, wr_mon;

  rtc_rst_sync rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  rtc_prescaler #(.PRE_W(PRE_W)) pre_i (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .tick_en   (tick_en),
    .cmd_clr   (cmd_prescale_clr),
    .cmd_adj   (cmd_round_adj),
    .trim_out  (trim_out),
    .sec_sq    (sec_sq),
    .min_sq    (min_sq),
    .min_carry (min_adv)
  );

  // write decode
  always_comb begin
    wr_min  = wr_en && (wr_sel == FLD_MIN);
    wr_hour = wr_en && (wr_sel == FLD_HOUR);
    wr_day  = wr_en && (wr_sel == FLD_DAY);
    wr_mon  = wr_en && (wr_sel == FLD_MON);
  end

  // wrap detection and carry chain; a written field passes no carry on
  always_comb begin
    min_top  = (8'(minutes) >= 8'h59);
    hour_top = (8'(hours)   >= 8'h23);
    day_top  = (8'(days)    >= month_last_day(8'(months)));
    mon_top  = (8'(months)  >= 8'h12);
    hour_adv = min_adv  && min_top  && !wr_min;
    day_adv  = hour_adv && hour_top && !wr_hour;
    mon_adv  = day_adv  && day_top  && !wr_day;
  end

  rtc_bcd_field #(.W(MIN_W), .RST_VAL(8'h00)) min_i (
    .clk (clk), .rst_n (rst_core_n), .adv (min_adv), .at_limit (min_top),
    .wr_en (wr_min), .wr_val (wr_data), .value (minutes)
  );

  rtc_bcd_field #(.W(HOUR_W), .RST_VAL(8'h00)) hour_i (
    .clk (clk), .rst_n (rst_core_n), .adv (hour_adv), .at_limit (hour_top),
    .wr_en (wr_hour), .wr_val (wr_data[HOUR_W-1:0]), .value (hours)
  );

  rtc_bcd_field #(.W(DAY_W), .RST_VAL(8'h01)) day_i (
    .clk (clk), .rst_n (rst_core_n), .adv (day_adv), .at_limit (day_top),
    .wr_en (wr_day), .wr_val (wr_data[DAY_W-1:0]), .value (days)
  );

  rtc_bcd_field #(.W(MON_W), .RST_VAL(8'h01)) mon_i (
    .clk (clk), .rst_n (rst_core_n), .adv (mon_adv), .at_limit (mon_top),
    .wr_en (wr_mon), .wr_val (wr_data[MON_W-1:0]), .value (months)
  );
endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk (
  input logic       clk,
  input logic       rst_core_n,
  input logic       tick_en,
  input logic       cmd_prescale_clr,
  input logic       cmd_round_adj,
  input logic       wr_en,
  input logic [1:0] wr_sel,
  input logic [6:0] wr_data,
  input logic       trim_out,
  input logic       sec_sq,
  input logic       min_sq,
  input logic [6:0] minutes,
  input logic [5:0] hours,
  input logic [5:0] days,
  input logic [4:0] months
);
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_core_n)
    !tick_en && !cmd_prescale_clr && !cmd_round_adj && !wr_en
    |=> $stable(sec_sq) && $stable(trim_out) && $stable(min_sq) && $stable(minutes)); // R10

  AST_CLR_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_core_n)
    cmd_prescale_clr && !cmd_round_adj && !wr_en
    |=> $stable(minutes) && !min_sq && !sec_sq && !trim_out); // R7

  AST_ADJ_EARLY_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    cmd_round_adj && !min_sq && !wr_en |=> $stable(minutes) && !sec_sq); // R8

  AST_MIN_ON_SQ_FALL: assert property (@(posedge clk) disable iff (!rst_core_n)
    $fell(min_sq) && !$past(cmd_prescale_clr) && !$past(wr_en)
    |-> minutes != $past(minutes)); // R4

  AST_MONTH_WRAP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (months != $past(months)) && ($past(months) == 5'h12) && !$past(wr_en)
    |-> months == 5'h01); // R5

  AST_DAY_ROLL_LIMIT: assert property (@(posedge clk) disable iff (!rst_core_n)
    (days == 6'h01) && ($past(days) != 6'h01) && !$past(wr_en)
    |-> $past(days) >= 6'h28); // R5

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_en && (wr_sel == 2'd0) |=> minutes == $past(wr_data)); // R9
endmodule

bind rtc_calendar_core rtc_calendar_core_chk chk_i (
  .clk              (clk),
  .rst_core_n       (rst_core_n),
  .tick_en          (tick_en),
  .cmd_prescale_clr (cmd_prescale_clr),
  .cmd_round_adj    (cmd_round_adj),
  .wr_en            (wr_en),
  .wr_sel           (wr_sel),
  .wr_data          (wr_data),
  .trim_out         (trim_out),
  .sec_sq           (sec_sq),
  .min_sq           (min_sq),
  .minutes          (minutes),
  .hours            (hours),
  .days             (days),
  .months           (months)
);

// File: tb/rtc_calendar_core_tb_top.sv
module rtc_calendar_core_tb_top;
  localparam int PRE_W   = 8;            // 256 ticks per second in the bench
  localparam int TPS     = 1 << PRE_W;
  localparam int NVEC    = 10;
  localparam int WD_MAX  = 190000;
  localparam logic [1:0] S_MIN = 2'd0, S_HOUR = 2'd1, S_DAY = 2'd2, S_MON = 2'd3;

  // {month, day, hour, minute} loaded, then expected after one minute carry
  localparam logic [63:0] VEC [NVEC] = '{
    64'h01_15_10_22_01_15_10_23,   // plain increment (R4)
    64'h01_15_10_59_01_15_11_00,   // minute carry (R4)
    64'h01_15_23_59_01_16_00_00,   // hour carry (R4)
    64'h04_30_23_59_05_01_00_00,   // 30-day month (R5)
    64'h01_30_23_59_01_31_00_00,   // 31-day month passes 30 (R5)
    64'h02_28_23_59_03_01_00_00,   // February 28 (R5)
    64'h02_29_23_59_03_01_00_00,   // written leap day (R6)
    64'h12_31_23_59_01_01_00_00,   // year wrap (R5)
    64'h11_30_23_59_12_01_00_00,   // 30-day month 11 (R5)
    64'h07_31_23_59_08_01_00_00    // 31-day month 7 (R5)
  };

  logic       clk;
  logic       rst_n;
  logic       tick_en;
  logic       cmd_prescale_clr;
  logic       cmd_round_adj;
  logic       wr_en;
  logic [1:0] wr_sel;
  logic [6:0] wr_data;
  logic       trim_out, sec_sq, min_sq;
  logic [6:0] minutes;
  logic [5:0] hours;
  logic [5:0] days;
  logic [4:0] months;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  rtc_calendar_core #(.PRE_W(PRE_W)) dut_i (
    .clk (clk), .rst_n (rst_n), .tick_en (tick_en),
    .cmd_prescale_clr (cmd_prescale_clr), .cmd_round_adj (cmd_round_adj),
    .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
    .trim_out (trim_out), .sec_sq (sec_sq), .min_sq (min_sq),
    .minutes (minutes), .hours (hours), .days (days), .months (months)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_field(input logic [1:0] sel, input logic [6:0] val);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_clr();
    cmd_prescale_clr = 1'b1;
    @(negedge clk);
    cmd_prescale_clr = 1'b0;
  endtask

  task automatic pulse_adj();
    cmd_round_adj = 1'b1;
    @(negedge clk);
    cmd_round_adj = 1'b0;
  endtask

  task automatic wait_late();
    while (!min_sq) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    step(WD_MAX);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; cmd_prescale_clr = 1'b0; cmd_round_adj = 1'b0;
    wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
    step(5);
    // R11 reset state
    chk("R11", "minutes", 8'(minutes), 8'h00);
    chk("R11", "hours",   8'(hours),   8'h00);
    chk("R11", "days",    8'(days),    8'h01);
    chk("R11", "months",  8'(months),  8'h01);
    chk("R11", "squares", {5'd0, trim_out, sec_sq, min_sq}, 8'h00);
    rst_n = 1'b1;
    step(4);

    // R10 no tick: nothing moves
    step(300);
    chk("R10", "idle squares", {5'd0, trim_out, sec_sq, min_sq}, 8'h00);

    // R1 / R2 phases from a clear
    tick_en = 1'b1;
    pulse_clr();
    chk("R1", "trim after clear", 8'(trim_out), 8'h00);
    step(1);
    chk("R1", "trim tick 1", 8'(trim_out), 8'h01);
    step(1);
    chk("R1", "trim tick 2", 8'(trim_out), 8'h00);
    step(TPS/2 - 3);
    chk("R2", "sec_sq before half", 8'(sec_sq), 8'h00);
    step(1);
    chk("R2", "sec_sq at half", 8'(sec_sq), 8'h01);
    step(TPS/2);
    chk("R2", "sec_sq at full", 8'(sec_sq), 8'h00);

    // R3 / R4 natural minute from a clear
    pulse_clr();
    step(30*TPS - 1);
    chk("R3", "min_sq at 29s", 8'(min_sq), 8'h00);
    step(1);
    chk("R3", "min_sq at 30s", 8'(min_sq), 8'h01);
    chk("R3", "sec_sq at 30s", 8'(sec_sq), 8'h00);
    step(30*TPS - 1);
    chk("R4", "minutes before carry", 8'(minutes), 8'h00);
    chk("R4", "min_sq before carry",  8'(min_sq),  8'h01);
    step(1);
    chk("R4", "minutes after carry", 8'(minutes), 8'h01);
    chk("R4", "min_sq after carry",  8'(min_sq),  8'h00);

    // R7 clear with late seconds: no carry
    wait_late();
    pulse_clr();
    chk("R7", "minutes kept", 8'(minutes), 8'h01);
    chk("R7", "min_sq cleared", 8'(min_sq), 8'h00);

    // R8 adjust with early seconds: no carry
    step(100);
    pulse_adj();
    chk("R8", "early adjust minutes", 8'(minutes), 8'h01);
    chk("R8", "early adjust sec_sq", 8'(sec_sq), 8'h00);

    // R8 both commands together with late seconds: adjust wins
    wait_late();
    cmd_prescale_clr = 1'b1;
    pulse_adj();
    cmd_prescale_clr = 1'b0;
    chk("R8", "both commands carry", 8'(minutes), 8'h02);

    // table walk: load a date, round-adjust with late seconds
    for (int i = 0; i < NVEC; i++) begin
      wait_late();
      wr_field(S_MON,  7'(VEC[i][60:56]));
      wr_field(S_DAY,  7'(VEC[i][53:48]));
      wr_field(S_HOUR, 7'(VEC[i][45:40]));
      wr_field(S_MIN,  VEC[i][38:32]);
      chk("R9", "loaded minutes", 8'(minutes), VEC[i][39:32]);
      pulse_adj();
      chk("R8", "vector min_sq", 8'(min_sq), 8'h00);
      chk("R4", "vector minutes", 8'(minutes), VEC[i][7:0]);
      chk("R4", "vector hours",   8'(hours),   VEC[i][15:8]);
      chk("R5", "vector days",    8'(days),    VEC[i][23:16]);
      chk("R5", "vector months",  8'(months),  VEC[i][31:24]);
    end

    // R9 write on the carrying field drops advance and carry
    wait_late();
    wr_field(S_HOUR, 7'h10);
    wr_field(S_MIN,  7'h59);
    cmd_round_adj = 1'b1; wr_en = 1'b1; wr_sel = S_MIN; wr_data = 7'h45;
    @(negedge clk);
    cmd_round_adj = 1'b0; wr_en = 1'b0;
    chk("R9", "written minutes win", 8'(minutes), 8'h45);
    chk("R9", "no carry to hours",   8'(hours),   8'h10);

    // R9 write on a downstream field: upstream still advances
    wait_late();
    wr_field(S_MIN, 7'h22);
    cmd_round_adj = 1'b1; wr_en = 1'b1; wr_sel = S_HOUR; wr_data = 7'h07;
    @(negedge clk);
    cmd_round_adj = 1'b0; wr_en = 1'b0;
    chk("R9", "minutes advance", 8'(minutes), 8'h23);
    chk("R9", "hours written",   8'(hours),   8'h07);

    // R10 tick removed in the late half: state frozen
    wait_late();
    tick_en = 1'b0;
    step(2*TPS);
    chk("R10", "frozen min_sq",  8'(min_sq),  8'h01);
    chk("R10", "frozen minutes", 8'(minutes), 8'h23);

    finish_run();
  end
endmodule